// File: doc/BRIEF.md
# Host-to-Slave Byte Mailbox Channel

This block is one byte-wide mailbox channel between an external host bus and an on-chip slave processor. It works like the command/data port of a keyboard controller. The host writes bytes into an inbound register and reads bytes from an outbound register. The slave processor does the reverse, and takes an interrupt request whenever an inbound byte is waiting.

A status byte describes the channel. Two flags report whether the inbound and outbound registers hold an unconsumed byte. A tag bit records whether the last host write was a command or data. Five general-purpose bits are owned by the slave.

The host side decodes plain I/O read and write strobes with a 16-bit address. The channel answers only inside a fixed 8-byte window. The slave side has its own small register file with read and write strobes. Both read paths are combinational. All state changes on the rising clock edge.

Top module: `hmbx_chan`

## Requirements
- R1: A host access is selected only when address bits [15:4] equal 0x006 and address bit 3 is 0. An unselected host write changes no state. An unselected host read returns 0.
- R2: A selected host write stores `h_wdata` in the inbound register and sets the inbound-full flag (status bit 1), for either value of address bit 2.
- R3: On each selected host write, address bit 2 is captured into status bit 3. A value of 1 marks a command and 0 marks data. Slave status writes never change bit 3 or bit 1.
- R4: A slave read of slave register 0 returns the inbound byte and clears the inbound-full flag. If a selected host write happens in the same cycle, the flag stays 1.
- R5: A slave write to slave register 1 loads the outbound register and sets the outbound-full flag (status bit 0). A selected host read with address bit 2 = 0 returns the outbound byte and clears the flag. If a slave outbound write happens in the same cycle, the flag stays 1.
- R6: A slave write to slave register 2 with data bit 0 = 0 clears the outbound-full flag. With data bit 0 = 1 the flag is left unchanged.
- R7: A slave write to slave register 2 loads status bits 7..4 and bit 2 from the written data. The host cannot change these bits.
- R8: A selected host read with address bit 2 = 1 returns the status byte when bits 1..0 = 00. It returns the auxiliary byte when bits 1..0 = 10, and 0 for the other two offsets. `h_rdata` is 0 whenever no selected read is active.
- R9: `irq` equals the inbound-full flag ANDed with the enable bit, which is bit 0 of slave register 4.
- R10: After reset every register and flag is 0.
- R11: The slave can write and read the auxiliary byte at slave register 3 and read the outbound byte at register 1. Slave register numbers 5..7 read as 0, and writes to them change nothing. `s_rdata` is 0 when `s_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | ADDR_W (16) | Host I/O address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_wdata | input | DATA_W (8) | Host write data |
| h_rdata | output | DATA_W (8) | Host read data, combinational |
| s_addr | input | 3 | Slave register number |
| s_wr | input | 1 | Slave write strobe |
| s_rd | input | 1 | Slave read strobe |
| s_wdata | input | DATA_W (8) | Slave write data |
| s_rdata | output | DATA_W (8) | Slave read data, combinational |
| irq | output | 1 | Level interrupt request to the slave |

## Verification
The bench builds the block with its defaults: a 16-bit address, 8-bit data, window tag 0x006 and the auxiliary register present. With these values the whole 8-byte window, including both unused status offsets, can be reached. Random addresses outside the window exercise the bit 3 and upper-field decode. Random slave and host strobes, including same-cycle collisions, reach both flag-priority rules and the slave's write-zero clear of the outbound flag.

// File: rtl/hmbx_pkg.sv
package hmbx_pkg;

   // Slave-side register numbers
   typedef enum logic [2:0] {
      SR_IDR = 3'd0,
      SR_ODR = 3'd1,
      SR_STS = 3'd2,
      SR_AUX = 3'd3,
      SR_CTL = 3'd4
   } slv_reg_e;

   // Status byte bit positions (the host decodes these)
   localparam int STS_OBF = 0;
   localparam int STS_IBF = 1;
   localparam int STS_CD  = 3;

   // Host offsets inside the window (address bits 1..0 when bit 2 = 1)
   localparam logic [1:0] HOFS_STS = 2'b00;
   localparam logic [1:0] HOFS_AUX = 2'b10;

endpackage

// File: rtl/hmbx_host_dec.sv
module hmbx_host_dec #(
   parameter int                ADDR_W   = 16,
   parameter logic [ADDR_W-5:0] CHAN_TAG = 'h006
) (
   input  logic [ADDR_W-1:0] h_addr,
   input  logic              h_wr,
   input  logic              h_rd,
   output logic              wr_idr,
   output logic              cd_bit,
   output logic              rd_odr,
   output logic              rd_sts,
   output logic              rd_aux
);
   import hmbx_pkg::*;

   logic hit;
   logic rd_hit;

   always_comb begin
      hit    = (h_addr[ADDR_W-1:4] == CHAN_TAG) && !h_addr[3];
      rd_hit = hit && h_rd;
      wr_idr = hit && h_wr;
      cd_bit = h_addr[2];
      rd_odr = rd_hit && !h_addr[2];
      rd_sts = rd_hit && h_addr[2] && (h_addr[1:0] == HOFS_STS);
      rd_aux = rd_hit && h_addr[2] && (h_addr[1:0] == HOFS_AUX);
   end

endmodule

// File: rtl/hmbx_flags.sv
module hmbx_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic host_wr,
   input  logic host_cd,
   input  logic host_rd_odr,
   input  logic slv_rd_idr,
   input  logic slv_wr_odr,
   input  logic slv_wr_sts,
   input  logic slv_obf_bit,
   output logic ibf,
   output logic obf,
   output logic cd
);

   // Set wins over clear on both flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ibf <= 1'b0;
         obf <= 1'b0;
         cd  <= 1'b0;
      end else begin
         if (host_wr) begin
            ibf <= 1'b1;
            cd  <= host_cd;
         end else if (slv_rd_idr) begin
            ibf <= 1'b0;
         end

         if (slv_wr_odr)
            obf <= 1'b1;
         else if (host_rd_odr || (slv_wr_sts && !slv_obf_bit))
            obf <= 1'b0;
      end
   end

endmodule

// File: rtl/hmbx_slave_regs.sv
module hmbx_slave_regs #(
   parameter int DATA_W = 8,
   parameter bit AUX_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [2:0]        s_addr,
   input  logic              s_wr,
   input  logic              s_rd,
   input  logic [DATA_W-1:0] s_wdata,
   input  logic              ibf,
   input  logic              obf,
   input  logic              cd,
   output logic [DATA_W-1:0] idr,
   output logic [DATA_W-1:0] odr,
   output logic [7:0]        sts,
   output logic [DATA_W-1:0] aux,
   output logic              ien,
   output logic [DATA_W-1:0] s_rdata
);
   import hmbx_pkg::*;

   logic [4:0] gp_q;   // status bits 7..4 and 2

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idr  <= '0;
         odr  <= '0;
         gp_q <= '0;
         ien  <= 1'b0;
      end else begin
         if (host_wr)
            idr <= host_wdata;
         if (s_wr) begin
            case (s_addr)
               SR_ODR:  odr  <= s_wdata;
               SR_STS:  gp_q <= {s_wdata[7:4], s_wdata[2]};
               SR_CTL:  ien  <= s_wdata[0];
               default: ;
            endcase
         end
      end
   end

   generate
      if (AUX_EN) begin : g_aux
         logic [DATA_W-1:0] aux_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               aux_q <= '0;
            else if (s_wr && (s_addr == SR_AUX))
               aux_q <= s_wdata;
         end
         assign aux = aux_q;
      end else begin : g_no_aux
         assign aux = '0;
      end
   endgenerate

   always_comb begin
      sts          = '0;
      sts[7:4]     = gp_q[4:1];
      sts[STS_CD]  = cd;
      sts[2]       = gp_q[0];
      sts[STS_IBF] = ibf;
      sts[STS_OBF] = obf;
   end

   always_comb begin
      s_rdata = '0;
      if (s_rd) begin
         case (s_addr)
            SR_IDR:  s_rdata = idr;
            SR_ODR:  s_rdata = odr;
            SR_STS:  s_rdata[7:0] = sts;
            SR_AUX:  s_rdata = aux;
            SR_CTL:  s_rdata[0] = ien;
            default: s_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/hmbx_chan.sv
module hmbx_chan #(
   parameter int                ADDR_W   = 16,
   parameter int                DATA_W   = 8,
   parameter logic [ADDR_W-5:0] CHAN_TAG = 'h006,
   parameter bit                AUX_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic              h_wr,
   input  logic              h_rd,
   input  logic [DATA_W-1:0] h_wdata,
   output logic [DATA_W-1:0] h_rdata,
   input  logic [2:0]        s_addr,
   input  logic              s_wr,
   input  logic              s_rd,
   input  logic [DATA_W-1:0] s_wdata,
   output logic [DATA_W-1:0] s_rdata,
   output logic              irq
);
   import hmbx_pkg::*;

   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("hmbx_chan: ADDR_W must be at least 5");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("hmbx_chan: DATA_W must be at least 8");
      end
   endgenerate

   logic              wr_idr, cd_bit, rd_odr, rd_sts, rd_aux;
   logic              ibf, obf, cd, ien;
   logic [DATA_W-1:0] idr, odr, aux;
   logic [7:0]        sts;
   logic              slv_rd_idr, slv_wr_odr, slv_wr_sts;

   assign slv_rd_idr = s_rd && (s_addr == SR_IDR);
   assign slv_wr_odr = s_wr && (s_addr == SR_ODR);
   assign slv_wr_sts = s_wr && (s_addr == SR_STS);

   hmbx_host_dec #(.ADDR_W(ADDR_W), .CHAN_TAG(CHAN_TAG)) u_dec (
      .h_addr (h_addr),
      .h_wr   (h_wr),
      .h_rd   (h_rd),
      .wr_idr (wr_idr),
      .cd_bit (cd_bit),
      .rd_odr (rd_odr),
      .rd_sts (rd_sts),
      .rd_aux (rd_aux)
   );

   hmbx_flags u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_wr     (wr_idr),
      .host_cd     (cd_bit),
      .host_rd_odr (rd_odr),
      .slv_rd_idr  (slv_rd_idr),
      .slv_wr_odr  (slv_wr_odr),
      .slv_wr_sts  (slv_wr_sts),
      .slv_obf_bit (s_wdata[STS_OBF]),
      .ibf         (ibf),
      .obf         (obf),
      .cd          (cd)
   );

   hmbx_slave_regs #(.DATA_W(DATA_W), .AUX_EN(AUX_EN)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (wr_idr),
      .host_wdata (h_wdata),
      .s_addr     (s_addr),
      .s_wr       (s_wr),
      .s_rd       (s_rd),
      .s_wdata    (s_wdata),
      .ibf        (ibf),
      .obf        (obf),
      .cd         (cd),
      .idr        (idr),
      .odr        (odr),
      .sts        (sts),
      .aux        (aux),
      .ien        (ien),
      .s_rdata    (s_rdata)
   );

   always_comb begin
      h_rdata = '0;
      if (rd_odr)
         h_rdata = odr;
      else if (rd_sts)
         h_rdata[7:0] = sts;
      else if (rd_aux)
         h_rdata = aux;
   end

   assign irq = ibf && ien;

endmodule

// File: rtl/hmbx_chan_chk.sv
module hmbx_chan_chk #(
   parameter int                ADDR_W   = 16,
   parameter logic [ADDR_W-5:0] CHAN_TAG = 'h006
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] h_addr,
   input logic              h_wr,
   input logic [2:0]        s_addr,
   input logic              s_wr,
   input logic              s_rd,
   input logic              ibf,
   input logic              obf,
   input logic              cd,
   input logic              irq
);
   logic host_w;
   assign host_w = h_wr && (h_addr[ADDR_W-1:4] == CHAN_TAG) && !h_addr[3];

   // R1
   ibf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ibf && !host_w) |=> !ibf);

   // R2
   ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_w |=> ibf);

   // R3
   cd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_w |=> (cd == $past(h_addr[2])));

   // R4
   ibf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rd && (s_addr == 3'd0) && !host_w) |=> !ibf);

   // R5
   obf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_wr && (s_addr == 3'd1)) |=> obf);

   // R6
   obf_no_self_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!obf && !(s_wr && (s_addr == 3'd1))) |=> !obf);

   // R9
   irq_needs_ibf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ibf);

endmodule

bind hmbx_chan hmbx_chan_chk #(.ADDR_W(ADDR_W), .CHAN_TAG(CHAN_TAG)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .h_addr (h_addr),
   .h_wr   (h_wr),
   .s_addr (s_addr),
   .s_wr   (s_wr),
   .s_rd   (s_rd),
   .ibf    (ibf),
   .obf    (obf),
   .cd     (cd),
   .irq    (irq)
);

// File: tb/hmbx_chan_bench.sv
module hmbx_chan_bench;

   localparam int CLK_NS = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] h_addr = '0;
   logic        h_wr = 1'b0, h_rd = 1'b0;
   logic [7:0]  h_wdata = '0, h_rdata;
   logic [2:0]  s_addr = '0;
   logic        s_wr = 1'b0, s_rd = 1'b0;
   logic [7:0]  s_wdata = '0, s_rdata;
   logic        irq;

   int n_cmp = 0;
   int n_bad = 0;

   // reference model
   logic [7:0] m_idr = 0, m_odr = 0, m_aux = 0;
   logic [4:0] m_gp = 0;
   logic       m_ibf = 0, m_obf = 0, m_cd = 0, m_ien = 0;

   always #(CLK_NS/2) clk = ~clk;

   hmbx_chan u_hmbx_chan (
      .clk(clk), .rst_n(rst_n),
      .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd), .h_wdata(h_wdata), .h_rdata(h_rdata),
      .s_addr(s_addr), .s_wr(s_wr), .s_rd(s_rd), .s_wdata(s_wdata), .s_rdata(s_rdata),
      .irq(irq)
   );

   function automatic logic sel(logic [15:0] a);
      return (a[15:4] == 12'h006) && !a[3];
   endfunction

   function automatic logic [7:0] exp_sts();
      return {m_gp[4:1], m_cd, m_gp[0], m_ibf, m_obf};
   endfunction

   function automatic logic [7:0] exp_host(logic [15:0] a, logic rd);
      if (!rd || !sel(a)) return 8'h00;
      if (!a[2]) return m_odr;
      if (a[1:0] == 2'b00) return exp_sts();
      if (a[1:0] == 2'b10) return m_aux;
      return 8'h00;
   endfunction

   function automatic logic [7:0] exp_slave(logic [2:0] sa, logic rd);
      if (!rd) return 8'h00;
      case (sa)
         3'd0: return m_idr;
         3'd1: return m_odr;
         3'd2: return exp_sts();
         3'd3: return m_aux;
         3'd4: return {7'b0, m_ien};
         default: return 8'h00;
      endcase
   endfunction

   task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
      end
   endtask

   // one cycle: drive at negedge, compare combinational outputs, advance model
   task automatic cyc(string tag, logic [15:0] ha, logic hw, logic hr, logic [7:0] hd,
                      logic [2:0] sa, logic sw, logic sr, logic [7:0] sd);
      logic hsel, ibf_n, obf_n;
      @(negedge clk);
      h_addr = ha; h_wr = hw; h_rd = hr; h_wdata = hd;
      s_addr = sa; s_wr = sw; s_rd = sr; s_wdata = sd;
      #1;
      chk(tag, h_rdata, exp_host(ha, hr));
      chk(tag, s_rdata, exp_slave(sa, sr));
      chk("R9", {7'b0, irq}, {7'b0, m_ibf & m_ien});
      hsel  = sel(ha);
      ibf_n = (hw && hsel) ? 1'b1 : ((sr && sa == 3'd0) ? 1'b0 : m_ibf);
      obf_n = (sw && sa == 3'd1) ? 1'b1 :
              (((hr && hsel && !ha[2]) || (sw && sa == 3'd2 && !sd[0])) ? 1'b0 : m_obf);
      if (hw && hsel) begin m_idr = hd; m_cd = ha[2]; end
      if (sw) begin
         case (sa)
            3'd1: m_odr = sd;
            3'd2: m_gp  = {sd[7:4], sd[2]};
            3'd3: m_aux = sd;
            3'd4: m_ien = sd[0];
            default: ;
         endcase
      end
      m_ibf = ibf_n;
      m_obf = obf_n;
   endtask

   task automatic hwr(string t, logic [15:0] a, logic [7:0] d); cyc(t, a, 1, 0, d, 0, 0, 0, 0); endtask
   task automatic hrd(string t, logic [15:0] a); cyc(t, a, 0, 1, 0, 0, 0, 0, 0); endtask
   task automatic swr(string t, logic [2:0] a, logic [7:0] d); cyc(t, 0, 0, 0, 0, a, 1, 0, d); endtask
   task automatic srd(string t, logic [2:0] a); cyc(t, 0, 0, 0, 0, a, 0, 1, 0); endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_NS * 150000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      repeat (3) @(negedge clk);
      // R10: reset state visible on both sides while held in reset
      #1;
      chk("R10", irq ? 8'h01 : 8'h00, 8'h00);
      @(negedge clk); rst_n = 1'b1;
      hrd("R10", 16'h0064);
      for (int i = 0; i < 5; i++) srd("R10", 3'(i));

      // R1: out-of-window writes leave the channel untouched
      hwr("R1", 16'h0068, 8'hAA);
      hwr("R1", 16'h0164, 8'hAB);
      hrd("R1", 16'h0064);
      srd("R1", 3'd0);
      hrd("R1", 16'h0070);

      // R2 / R3: command write then data write share one register
      hwr("R3", 16'h0064, 8'h5A);
      hrd("R3", 16'h0064);
      srd("R2", 3'd0);
      hwr("R3", 16'h0060, 8'h33);
      hrd("R3", 16'h0064);
      srd("R2", 3'd0);

      // R4: host write collides with slave read
      hwr("R4", 16'h0061, 8'h11);
      cyc("R4", 16'h0064, 1, 0, 8'h22, 3'd0, 0, 1, 0);
      hrd("R4", 16'h0064);
      srd("R4", 3'd0);
      hrd("R4", 16'h0064);

      // R9: interrupt follows the flag when enabled
      swr("R9", 3'd4, 8'h01);
      hwr("R9", 16'h0062, 8'h44);
      srd("R9", 3'd4);
      srd("R9", 3'd0);
      hrd("R9", 16'h0064);

      // R5: outbound path and collision
      swr("R5", 3'd1, 8'h77);
      hrd("R5", 16'h0064);
      hrd("R5", 16'h0063);
      hrd("R5", 16'h0064);
      swr("R5", 3'd1, 8'h78);
      cyc("R5", 16'h0060, 0, 1, 0, 3'd1, 1, 0, 8'h79);
      hrd("R5", 16'h0064);
      srd("R11", 3'd1);

      // R6 / R7: status writes
      swr("R7", 3'd2, 8'hFF);
      hrd("R7", 16'h0064);
      swr("R6", 3'd2, 8'h01);
      hrd("R6", 16'h0064);
      swr("R6", 3'd2, 8'h00);
      hrd("R6", 16'h0064);
      swr("R6", 3'd2, 8'hFF);
      hrd("R6", 16'h0064);
      hwr("R7", 16'h0064, 8'h00);
      hrd("R7", 16'h0064);

      // R8 / R11: auxiliary byte and unused offsets
      swr("R11", 3'd3, 8'hC3);
      hrd("R8", 16'h0066);
      hrd("R8", 16'h0065);
      hrd("R8", 16'h0067);
      srd("R11", 3'd3);
      swr("R11", 3'd6, 8'hEE);
      srd("R11", 3'd6);
      srd("R11", 3'd7);

      // random mix
      for (int n = 0; n < 4000; n++) begin
         logic [15:0] a;
         logic [1:0]  hop, sop;
         a   = ($urandom % 4 != 0) ? {12'h006, 1'b0, 3'($urandom)} : 16'($urandom);
         hop = 2'($urandom % 3);
         sop = 2'($urandom % 3);
         cyc("R8", a, hop == 1, hop == 2, 8'($urandom),
             3'($urandom), sop == 1, sop == 2, 8'($urandom));
      end

      @(negedge clk);
      h_wr = 0; h_rd = 0; s_wr = 0; s_rd = 0;
      finish_run();
   end

endmodule